// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block owns the program counter and the fetch control of a short in-order pipeline whose instructions are all one 32-bit word. Every cycle it presents a word address to instruction memory, which returns the addressed word in the same cycle. The block then latches that word, with its address, into a decode register for the next stage. Addresses count whole instruction words, not bytes.

Control transfers are delayed by one instruction. Unconditional jumps are recognised in decode, and their target is fetched in the very next cycle. Conditional branches compute their target in decode, but the taken/not-taken decision arrives one cycle later from the execute stage. In both cases the word that directly follows the transfer, called the slot, has already been fetched. It always flows on and is never discarded.

The `stall` input is the only back-pressure. While it is high, the program counter, the decode register and the pending-branch state hold their values. The fetch address can still show a redirect while the pipeline is stalled. A consumer that is not ready keeps `stall` high until it can accept the decode word.

Top module: `fseq_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `fetch_addr` is 0 and `dec_valid` is 0, and no conditional branch is pending.
- R2: When the decode word is not a control transfer and no taken branch is in execute, the next fetch address is the current one plus one word.
- R3: On every cycle without stall, the decode register loads `imem_data` and `fetch_addr`, and `dec_valid` becomes 1.
- R4: Opcode bits [31:26] equal to 0x02 or 0x03 mark a jump. The next fetch goes to the address built from the bits of (`dec_pc`+1) above bit 25, joined with instruction bits [25:0]. The slot word always reaches decode: a jump at 101 naming 105 gives the decode order 101, 102, 105.
- R5: Opcodes 0x04 to 0x07 mark a conditional branch. Its target is `dec_pc`+1 plus the sign-extended bits [15:0]. When `ex_taken` is high in the cycle the branch sits in execute, the fetch address in that cycle is the target.
- R6: `ex_taken` has no effect while execute holds no conditional branch, including when it holds a jump.
- R7: A jump or taken branch in the slot of another transfer is applied after exactly one further instruction: the most recent transfer wins from then on.
- R8: While `stall` is high, the decode outputs hold their values and neither the program counter nor the pending branch advances.
- R9: Every other opcode value is treated as plain sequential code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold PC, decode register and pending branch |
| imem_data | input | 32 | Word read at `fetch_addr` this cycle |
| ex_taken | input | 1 | Condition result for the branch in execute |
| fetch_addr | output | AW (30) | Word address to fetch this cycle |
| dec_valid | output | 1 | Decode register holds a fetched word |
| dec_instr | output | 32 | Word passed to decode |
| dec_pc | output | AW (30) | Word address of `dec_instr` |

## Verification
The bound checker watches several properties on every clock:
- the reset start;
- the capture of the fetched word and address into decode;
- sequential advance after plain code;
- the jump target in the cycle after a jump decodes;
- the branch target in a taken cycle;
- the hold of the decode register under stall.

Some behaviours only the bench's scenarios can show. These are the order of instructions reaching decode around a jump, a transfer placed in a slot, and `ex_taken` being ignored over plain code and jumps. The bench also runs long random mixes of stall and taken patterns and compares them against its own model.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned JFIELD_W = 26;
  localparam int unsigned OFF_W    = 16;

  localparam logic [OPC_W-1:0] OPC_JMP_A = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JMP_B = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BR_LO = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BR_HI = 6'h07;

  typedef enum logic [1:0] {
    CF_SEQ    = 2'd0,
    CF_JUMP   = 2'd1,
    CF_BRANCH = 2'd2
  } cf_kind_e;

  function automatic cf_kind_e classify(input logic [INSTR_W-1:0] word);
    logic [OPC_W-1:0] opc;
    opc = word[INSTR_W-1 -: OPC_W];
    if (opc == OPC_JMP_A || opc == OPC_JMP_B)
      return CF_JUMP;
    else if (opc >= OPC_BR_LO && opc <= OPC_BR_HI)
      return CF_BRANCH;
    else
      return CF_SEQ;
  endfunction

endpackage

// File: rtl/fseq_predecode.sv
module fseq_predecode
  import fseq_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic                dec_valid,
  input  logic [INSTR_W-1:0]  dec_instr,
  input  logic [AW-1:0]       dec_pc,
  output logic                is_jump,
  output logic                is_branch,
  output logic [AW-1:0]       jump_tgt,
  output logic [AW-1:0]       branch_tgt
);

  cf_kind_e      kind;
  logic [AW-1:0] slot_pc;
  logic [AW-1:0] off_ext;

  always_comb begin
    kind      = classify(dec_instr);
    is_jump   = dec_valid && (kind == CF_JUMP);
    is_branch = dec_valid && (kind == CF_BRANCH);
  end

  assign slot_pc    = dec_pc + AW'(1);
  assign off_ext    = AW'($signed(dec_instr[OFF_W-1:0]));
  assign branch_tgt = slot_pc + off_ext;

  generate
    if (AW > JFIELD_W) begin : g_wide
      assign jump_tgt = {slot_pc[AW-1:JFIELD_W], dec_instr[JFIELD_W-1:0]};
    end else begin : g_narrow
      assign jump_tgt = dec_instr[AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/fseq_pipe.sv
module fseq_pipe
  import fseq_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic [AW-1:0]       fetch_addr,
  input  logic [INSTR_W-1:0]  fetch_word,
  input  logic                dec_is_branch,
  input  logic [AW-1:0]       dec_br_tgt,
  output logic                dec_valid_o,
  output logic [INSTR_W-1:0]  dec_instr_o,
  output logic [AW-1:0]       dec_pc_o,
  output logic                ex_br_valid_o,
  output logic [AW-1:0]       ex_br_tgt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o   <= 1'b0;
      dec_instr_o   <= '0;
      dec_pc_o      <= '0;
      ex_br_valid_o <= 1'b0;
      ex_br_tgt_o   <= '0;
    end else if (advance) begin
      dec_valid_o   <= 1'b1;
      dec_instr_o   <= fetch_word;
      dec_pc_o      <= fetch_addr;
      ex_br_valid_o <= dec_is_branch;
      ex_br_tgt_o   <= dec_br_tgt;
    end
  end

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int unsigned AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          take_jump,
  input  logic [AW-1:0] jump_tgt,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_tgt,
  output logic [AW-1:0] fetch_addr
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;

  always_comb begin
    fetch_addr = redirect ? redirect_tgt : pc_q;
    pc_d       = take_jump ? jump_tgt : (fetch_addr + AW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= '0;
    else if (advance)
      pc_q <= pc_d;
  end

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic [INSTR_W-1:0]  imem_data,
  input  logic                ex_taken,
  output logic [AW-1:0]       fetch_addr,
  output logic                dec_valid,
  output logic [INSTR_W-1:0]  dec_instr,
  output logic [AW-1:0]       dec_pc
);

  logic          advance;
  logic          is_jump;
  logic          is_branch;
  logic [AW-1:0] jump_tgt;
  logic [AW-1:0] branch_tgt;
  logic          ex_br_valid;
  logic [AW-1:0] ex_br_tgt;
  logic          redirect;

  assign advance  = !stall;
  assign redirect = ex_br_valid && ex_taken;

  fseq_predecode #(.AW(AW)) u_predecode (
    .dec_valid  (dec_valid),
    .dec_instr  (dec_instr),
    .dec_pc     (dec_pc),
    .is_jump    (is_jump),
    .is_branch  (is_branch),
    .jump_tgt   (jump_tgt),
    .branch_tgt (branch_tgt)
  );

  fseq_pipe #(.AW(AW)) u_pipe (
    .clk           (clk),
    .rst_n         (rst_n),
    .advance       (advance),
    .fetch_addr    (fetch_addr),
    .fetch_word    (imem_data),
    .dec_is_branch (is_branch),
    .dec_br_tgt    (branch_tgt),
    .dec_valid_o   (dec_valid),
    .dec_instr_o   (dec_instr),
    .dec_pc_o      (dec_pc),
    .ex_br_valid_o (ex_br_valid),
    .ex_br_tgt_o   (ex_br_tgt)
  );

  fseq_pc #(.AW(AW)) u_pc (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance      (advance),
    .take_jump    (is_jump),
    .jump_tgt     (jump_tgt),
    .redirect     (redirect),
    .redirect_tgt (ex_br_tgt),
    .fetch_addr   (fetch_addr)
  );

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker
  import fseq_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stall,
  input logic                ex_taken,
  input logic                redirect,
  input logic [AW-1:0]       fetch_addr,
  input logic                dec_valid,
  input logic [INSTR_W-1:0]  dec_instr,
  input logic [AW-1:0]       dec_pc
);

  localparam logic [AW-1:0] LOWMASK = AW'((64'd1 << JFIELD_W) - 64'd1);

  logic          dec_jump;
  logic          dec_branch;
  logic          dec_plain;
  logic [AW-1:0] exp_jump;
  logic [AW-1:0] exp_branch;

  always_comb begin
    dec_jump   = dec_valid && (classify(dec_instr) == CF_JUMP);
    dec_branch = dec_valid && (classify(dec_instr) == CF_BRANCH);
    dec_plain  = dec_valid && (classify(dec_instr) == CF_SEQ);
    exp_jump   = ((dec_pc + AW'(1)) & ~LOWMASK) | (AW'(dec_instr[JFIELD_W-1:0]) & LOWMASK);
    exp_branch = dec_pc + AW'(1) + AW'($signed(dec_instr[OFF_W-1:0]));
  end

  p_reset_start_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (fetch_addr == '0 && !dec_valid));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (dec_valid && dec_pc == $past(fetch_addr)));

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && dec_plain && !redirect) |=> (fetch_addr == $past(fetch_addr) + AW'(1)));

  p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && dec_jump) |=> (fetch_addr == $past(exp_jump)));

  p_branch_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!stall && dec_branch) && ex_taken) |-> (fetch_addr == $past(exp_branch)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(dec_instr) && $stable(dec_pc) && $stable(dec_valid)));

endmodule

bind fseq_top fseq_checker #(.AW(AW)) u_fseq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .ex_taken   (ex_taken),
  .redirect   (redirect),
  .fetch_addr (fetch_addr),
  .dec_valid  (dec_valid),
  .dec_instr  (dec_instr),
  .dec_pc     (dec_pc)
);

// File: tb/sim_fseq_top.sv
module sim_fseq_top;

  localparam int unsigned AW       = 30;
  localparam time         CLK_PER  = 10ns;
  localparam int          WD_LIMIT = 150000;
  localparam logic [AW-1:0] LOWMASK = AW'(32'h03FF_FFFF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic [31:0]   imem_data = '0;
  logic          ex_taken = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          dec_valid;
  logic [31:0]   dec_instr;
  logic [AW-1:0] dec_pc;

  always #(CLK_PER/2) clk = ~clk;

  fseq_top #(.AW(AW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .imem_data  (imem_data),
    .ex_taken   (ex_taken),
    .fetch_addr (fetch_addr),
    .dec_valid  (dec_valid),
    .dec_instr  (dec_instr),
    .dec_pc     (dec_pc)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_tag  = "R1";
  bit    rnd_mode = 1'b0;
  logic [31:0] prog [int];

  // reference state after the most recent edge
  logic [AW-1:0] m_pc;
  logic          m_dv;
  logic [31:0]   m_di;
  logic [AW-1:0] m_dp;
  logic          m_pend;
  logic [AW-1:0] m_ptgt;

  bit seen101, seen102, seen103, seen104, seen105;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hashw(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] h;
    logic [5:0]  opc;
    if (prog.exists(int'(a))) return prog[int'(a)];
    if (!rnd_mode) return 32'h0;
    h = hashw({2'b00, a});
    case (h[3:0])
      4'd0:       return {6'h02, 17'd0, h[12:4]};
      4'd1:       return {6'h03, 17'd0, h[12:4]};
      4'd2, 4'd3, 4'd4:
                  return {4'b0001, h[5:4], 10'h155, {10{h[21]}}, h[21:16]};
      default: begin
        opc = h[31:26];
        if (opc >= 6'h02 && opc <= 6'h07) opc = 6'h23;
        return {opc, h[25:0]};
      end
    endcase
  endfunction

  // one cycle, entered just after a falling edge
  task automatic step(input bit st, input bit tk);
    logic [AW-1:0] exp_fetch;
    logic [AW-1:0] nxt_pc;
    logic [5:0]    opc;
    check(cur_tag, "dec_valid", {31'd0, dec_valid}, {31'd0, m_dv});
    check(cur_tag, "dec_instr", dec_instr, m_di);
    check(cur_tag, "dec_pc", {2'b00, dec_pc}, {2'b00, m_dp});
    if (dec_valid) begin
      if (dec_pc == 30'd101) seen101 = 1'b1;
      if (dec_pc == 30'd102) seen102 = 1'b1;
      if (dec_pc == 30'd103) seen103 = 1'b1;
      if (dec_pc == 30'd104) seen104 = 1'b1;
      if (dec_pc == 30'd105) seen105 = 1'b1;
    end
    stall    = st;
    ex_taken = tk;
    #1;
    exp_fetch = (m_pend && tk) ? m_ptgt : m_pc;
    check(cur_tag, "fetch_addr", {2'b00, fetch_addr}, {2'b00, exp_fetch});
    imem_data = mem_word(exp_fetch);
    if (!st) begin
      opc    = m_di[31:26];
      nxt_pc = exp_fetch + AW'(1);
      if (m_dv && (opc == 6'h02 || opc == 6'h03))
        nxt_pc = ((m_dp + AW'(1)) & ~LOWMASK) | (AW'(m_di[25:0]) & LOWMASK);
      m_pend = m_dv && (opc >= 6'h04) && (opc <= 6'h07);
      m_ptgt = m_dp + AW'(1) + AW'($signed(m_di[15:0]));
      m_dv   = 1'b1;
      m_di   = imem_data;
      m_dp   = exp_fetch;
      m_pc   = nxt_pc;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input int stall_pct, input int taken_pct);
    for (int i = 0; i < n; i++)
      step(($urandom_range(99) < stall_pct), ($urandom_range(99) < taken_pct));
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete within %0d cycles", WD_LIMIT);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fetch_addr in reset", {2'b00, fetch_addr}, 32'd0);
    check("R1", "dec_valid in reset", {31'd0, dec_valid}, 32'd0);
    m_pc = '0; m_dv = 1'b0; m_di = '0; m_dp = '0; m_pend = 1'b0; m_ptgt = '0;
    rst_n = 1'b1;
    cur_tag = "R1";
    step(1'b0, 1'b1);

    // R2: plain sequential code
    cur_tag = "R2";
    run(8, 0, 0);

    // R6: taken flag over plain code only
    cur_tag = "R6";
    run(8, 0, 100);

    // R4: jump to 100, then jump at 101 naming 105 with slot 102
    cur_tag = "R4";
    prog[20]  = {6'h02, 26'd100};
    prog[101] = {6'h02, 26'd105};
    seen101 = 0; seen102 = 0; seen103 = 0; seen104 = 0; seen105 = 0;
    run(20, 0, 0);
    check("R4", "order 101,102,105 with 103-104 skipped",
          {27'd0, seen101, seen102, seen103, seen104, seen105}, 32'b11001);

    // R5: taken branches forward and backward
    cur_tag = "R5";
    prog[130] = {6'h04, 10'h000, 16'd5};
    prog[140] = {6'h05, 10'h000, 16'hFFE2};
    run(60, 0, 100);

    // R7: transfer in a slot, for jumps and for a branch
    cur_tag = "R7";
    prog[115] = {6'h02, 26'd200};
    prog[116] = {6'h03, 26'd300};
    prog[300] = {6'h06, 10'h000, 16'd10};
    prog[301] = {6'h02, 26'd400};
    run(60, 0, 100);

    // R3: mixed words flowing into decode
    prog.delete();
    rnd_mode = 1'b1;
    cur_tag = "R3";
    run(200, 0, 30);

    // R8: heavy stalling
    cur_tag = "R8";
    run(300, 50, 50);

    // R9: all opcode classes with mixed stall and taken
    cur_tag = "R9";
    run(3000, 20, 50);

    finish_run();
  end

endmodule